// File: doc/BRIEF.md
# Frequency Synthesizer Serial Programmer

This block writes one 24-bit programming word into an external frequency-synthesizer chip. It drives that chip over a two-wire serial link made of a clock line and a data line. A one-cycle start request latches five integer fields and packs them into the word: register select, VCO band index, feedback divider P, post divider M and reference divider Q. The block then plays a fixed line sequence:

- an unlock preamble;
- a start pattern;
- the 24 word bits, least significant first, each bit sent as four line states (complement first, then true value);
- a closing stop pattern.

Every line state is held for a programmable number of system clocks, so the external chip's setup and hold times can be met at any system clock rate. After the stop pattern the block waits a programmable settling time and then pulses done. The block does no frequency arithmetic. It only range-checks, packs and shifts the integers it is given. If P or Q is out of range, the request is refused with a one-cycle error pulse. The hold divider and the settling count must stay stable while a transfer is in progress.

Top module: `clksyn_loader`

## Requirements
- R1: After reset, and whenever busy_o is low, ser_clk_o and ser_dat_o are both 1, and busy_o, done_o and err_o are all 0.
- R2: The word is packed with reg_sel_i in bits 23..21, vco_band_i in bits 20..17, p_div_i minus 3 in bits 16..10, post_div_i in bits 9..7, and q_div_i minus 2 in bits 6..0.
- R3: A start request while idle is refused when p_div_i is outside 4..130 or q_div_i is outside 15..71. A refusal gives err_o high for exactly the one cycle after the request, busy_o stays low and the lines stay high.
- R4: The line sequence begins with five pairs of states, each pair being (data 1, clock 0) then (data 1, clock 1).
- R5: Next come two pairs of states, each pair being (data 0, clock 0) then (data 0, clock 1).
- R6: The 24 word bits follow, least significant bit first. Bit b is sent as four states: (not b, clock 1), (not b, clock 0), (b, clock 0), (b, clock 1). The value on the data line at each rising edge of the serial clock is therefore the true bit.
- R7: The sequence ends with three states with data 1: clock 1, then clock 0, then clock 1.
- R8: Every one of the 113 line states is held for exactly hold_div_i+1 system clocks. The first state appears in the cycle after the accepted start request.
- R9: After the last state, busy_o stays high with both lines high for settle_cyc_i+1 cycles. Then done_o is high for exactly one cycle, and in that cycle busy_o is already low.
- R10: A start request while busy_o is high is ignored. The transfer in progress continues unchanged and err_o stays low.
- R11: busy_o goes high in the cycle after an accepted start request and stays high through the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| reg_sel_i | input | 3 | Target register select |
| vco_band_i | input | 4 | VCO band index |
| p_div_i | input | 8 | Feedback divider P (4..130) |
| post_div_i | input | 3 | Post divider M |
| q_div_i | input | 7 | Reference divider Q (15..71) |
| hold_div_i | input | DIV_W | Line-state hold length minus one, in system clocks |
| settle_cyc_i | input | SETTLE_W | Settling wait length minus one, in system clocks |
| ser_clk_o | output | 1 | Serial clock line to the synthesizer |
| ser_dat_o | output | 1 | Serial data line to the synthesizer |
| busy_o | output | 1 | Transfer or settling in progress |
| done_o | output | 1 | One-cycle pulse when settling ends |
| err_o | output | 1 | One-cycle pulse when a request is refused |

## Verification
The embedded assertions check on every cycle the properties that do not depend on a particular sequence:

- lines high whenever idle;
- a refusal never coinciding with busy;
- done being a single-cycle pulse that only follows the settling phase;
- the hold counter never passing its limit;
- the step index never running past the stop pattern;
- a load never happening mid-transfer.

Only the bench's scenarios can show the following:

- the exact order of the 113 line states;
- the packing of the fields into the word;
- the per-state hold length and the settling length;
- a start during a transfer leaving the serial stream untouched.

To show these, the bench decodes the serial line at each rising clock edge and rebuilds the word.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  localparam int WORD_W       = 24;
  localparam int PRE_PAIRS    = 5;
  localparam int START_PAIRS  = 2;
  localparam int PH_PER_BIT   = 4;
  localparam int STOP_STATES  = 3;

  localparam int PRE_STATES   = 2 * PRE_PAIRS;
  localparam int START_STATES = 2 * START_PAIRS;
  localparam int DATA_STATES  = WORD_W * PH_PER_BIT;
  localparam int DATA_BASE    = PRE_STATES + START_STATES;
  localparam int STOP_BASE    = DATA_BASE + DATA_STATES;
  localparam int TOTAL_STATES = STOP_BASE + STOP_STATES;
  localparam int STEP_W       = $clog2(TOTAL_STATES);

  localparam int P_MIN = 4;
  localparam int P_MAX = 130;
  localparam int Q_MIN = 15;
  localparam int Q_MAX = 71;
  localparam int P_BIAS = 3;
  localparam int Q_BIAS = 2;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_SHIFT  = 2'd1,
    LD_SETTLE = 2'd2
  } ld_state_e;

  typedef struct packed {
    logic [2:0] sel;
    logic [3:0] band;
    logic [7:0] p;
    logic [2:0] m;
    logic [6:0] q;
  } syn_fields_t;

endpackage

// File: rtl/clksyn_pack.sv
module clksyn_pack
  import clksyn_pkg::*;
(
  input  syn_fields_t        fields_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               legal_o
);

  logic [7:0] p_bias;
  logic [6:0] q_bias;
  logic       p_ok;
  logic       q_ok;

  always_comb begin
    p_bias  = fields_i.p - 8'(P_BIAS);
    q_bias  = fields_i.q - 7'(Q_BIAS);
    p_ok    = (fields_i.p >= 8'(P_MIN)) && (fields_i.p <= 8'(P_MAX));
    q_ok    = (fields_i.q >= 7'(Q_MIN)) && (fields_i.q <= 7'(Q_MAX));
    legal_o = p_ok && q_ok;
    word_o  = {fields_i.sel, fields_i.band, p_bias[6:0], fields_i.m, q_bias};
  end

endmodule

// File: rtl/clksyn_pace.sv
module clksyn_pace #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             adv_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_lim;

  always_comb begin
    at_lim = (cnt_q == div_i);
    cnt_en = restart_i || run_i;
    if (restart_i || at_lim) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
    adv_o  = run_i && at_lim;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: hold counter never passes the programmed limit
  p_cnt_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    run_i |-> (cnt_q <= div_i));

endmodule

// File: rtl/clksyn_seq.sv
module clksyn_seq
  import clksyn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_i,
  output logic              line_clk_o,
  output logic              line_dat_o,
  output logic              last_o
);

  localparam logic [STEP_W-1:0] START_B = STEP_W'(PRE_STATES);
  localparam logic [STEP_W-1:0] DATA_B  = STEP_W'(DATA_BASE);
  localparam logic [STEP_W-1:0] STOP_B  = STEP_W'(STOP_BASE);
  localparam logic [STEP_W-1:0] LAST_S  = STEP_W'(TOTAL_STATES - 1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic [WORD_W-1:0] word_q;
  logic              step_en;
  logic [STEP_W-1:0] rel_data;
  logic [STEP_W-1:0] rel_stop;
  logic [WORD_W-1:0] word_sh;
  logic              cur_bit;

  always_comb begin
    step_en = load_i || adv_i;
    if (load_i)                       step_d = '0;
    else if (step_q == LAST_S)        step_d = step_q;
    else                              step_d = step_q + 1'b1;
    last_o  = adv_i && (step_q == LAST_S);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  // line state decode: preamble, start, data (four phases per bit), stop
  always_comb begin
    rel_data = step_q - DATA_B;
    rel_stop = step_q - STOP_B;
    word_sh  = word_q >> rel_data[STEP_W-1:2];
    cur_bit  = word_sh[0];
    if (step_q < START_B) begin
      line_dat_o = 1'b1;
      line_clk_o = step_q[0];
    end else if (step_q < DATA_B) begin
      line_dat_o = 1'b0;
      line_clk_o = step_q[0];
    end else if (step_q < STOP_B) begin
      unique case (rel_data[1:0])
        2'd0:    begin line_dat_o = ~cur_bit; line_clk_o = 1'b1; end
        2'd1:    begin line_dat_o = ~cur_bit; line_clk_o = 1'b0; end
        2'd2:    begin line_dat_o =  cur_bit; line_clk_o = 1'b0; end
        default: begin line_dat_o =  cur_bit; line_clk_o = 1'b1; end
      endcase
    end else begin
      line_dat_o = 1'b1;
      line_clk_o = (rel_stop != STEP_W'(1));
    end
  end

  // R10: the word is only ever loaded while the block is idle
  p_load_only_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |-> !busy_i);

  // R8: step index never runs past the last stop state
  p_step_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    step_q <= LAST_S);

  // R8: the line state only moves on a pacing tick or a load
  p_step_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!adv_i && !load_i) |=> $stable(step_q));

endmodule

// File: rtl/clksyn_loader.sv
module clksyn_loader
  import clksyn_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SETTLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                start_i,
  input  logic [2:0]          reg_sel_i,
  input  logic [3:0]          vco_band_i,
  input  logic [7:0]          p_div_i,
  input  logic [2:0]          post_div_i,
  input  logic [6:0]          q_div_i,
  input  logic [DIV_W-1:0]    hold_div_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  output logic                ser_clk_o,
  output logic                ser_dat_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  syn_fields_t       fields;
  logic [WORD_W-1:0] word;
  logic              legal;

  assign fields = '{sel: reg_sel_i, band: vco_band_i, p: p_div_i,
                    m: post_div_i, q: q_div_i};

  clksyn_pack u_pack (
    .fields_i (fields),
    .word_o   (word),
    .legal_o  (legal)
  );

  ld_state_e           state_q, state_d;
  logic [SETTLE_W-1:0] scnt_q, scnt_d;
  logic                scnt_en;
  logic                done_q, done_d;
  logic                err_q, err_d;
  logic                accept;
  logic                adv;
  logic                last;
  logic                line_clk, line_dat;
  logic                shifting;

  assign shifting = (state_q == LD_SHIFT);

  clksyn_pace #(.DIV_W(DIV_W)) u_pace (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .restart_i (accept),
    .run_i     (shifting),
    .div_i     (hold_div_i),
    .adv_o     (adv)
  );

  clksyn_seq u_seq (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .load_i     (accept),
    .busy_i     (busy_o),
    .word_i     (word),
    .adv_i      (adv),
    .line_clk_o (line_clk),
    .line_dat_o (line_dat),
    .last_o     (last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    scnt_en = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    accept  = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (start_i) begin
          if (legal) begin
            accept  = 1'b1;
            state_d = LD_SHIFT;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      LD_SHIFT: begin
        if (last) begin
          state_d = LD_SETTLE;
          scnt_d  = '0;
          scnt_en = 1'b1;
        end
      end
      LD_SETTLE: begin
        scnt_en = 1'b1;
        if (scnt_q == settle_cyc_i) begin
          state_d = LD_IDLE;
          done_d  = 1'b1;
          scnt_d  = '0;
        end else begin
          scnt_d = scnt_q + 1'b1;
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       scnt_q <= '0;
    else if (scnt_en) scnt_q <= scnt_d;
  end

  assign busy_o    = (state_q != LD_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign ser_clk_o = shifting ? line_clk : 1'b1;
  assign ser_dat_o = shifting ? line_dat : 1'b1;

  // R1: both lines rest high whenever the block is not busy
  p_idle_lines_high_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> (ser_clk_o && ser_dat_o));

  // R3: a refusal never coincides with a running transfer
  p_err_not_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> !busy_o);

  // R3: a refusal lasts one cycle
  p_err_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |=> !err_o);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: done only follows the settling phase
  p_done_after_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_o) |-> $past(state_q == LD_SETTLE));

endmodule

// File: tb/clksyn_loader_tb_top.sv
`timescale 1ns/1ps
module clksyn_loader_tb_top;

  localparam int DIV_W    = 16;
  localparam int SETTLE_W = 24;
  localparam int NSTATES  = 113;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [2:0]          sel;
  logic [3:0]          band;
  logic [7:0]          pdiv;
  logic [2:0]          mdiv;
  logic [6:0]          qdiv;
  logic [DIV_W-1:0]    hold;
  logic [SETTLE_W-1:0] settle;
  logic                sclk, sdat, busy, done, err;

  int n_cmp;
  int n_bad;
  int cyc;

  clksyn_loader #(.DIV_W(DIV_W), .SETTLE_W(SETTLE_W)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start),
    .reg_sel_i(sel), .vco_band_i(band), .p_div_i(pdiv),
    .post_div_i(mdiv), .q_div_i(qdiv), .hold_div_i(hold),
    .settle_cyc_i(settle), .ser_clk_o(sclk), .ser_dat_o(sdat),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected {dat,clk} for line state s, from R4..R7
  function automatic logic [1:0] exp_line(input int s, input logic [23:0] w);
    logic b;
    if (s < 10)  return {1'b1, 1'(s % 2)};
    if (s < 14)  return {1'b0, 1'(s % 2)};
    if (s < 110) begin
      b = w[(s - 14) / 4];
      case ((s - 14) % 4)
        0: return {~b, 1'b1};
        1: return {~b, 1'b0};
        2: return { b, 1'b0};
        default: return {b, 1'b1};
      endcase
    end
    return {1'b1, 1'(s != 111)};
  endfunction

  task automatic set_fields(input int k);
    case (k)
      0: begin sel = 3'd0; band = 4'd0;  pdiv = 8'd4;   mdiv = 3'd0; qdiv = 7'd15; end
      1: begin sel = 3'd7; band = 4'd15; pdiv = 8'd130; mdiv = 3'd7; qdiv = 7'd71; end
      2: begin sel = 3'd5; band = 4'd9;  pdiv = 8'd77;  mdiv = 3'd3; qdiv = 7'd40; end
      default: begin sel = 3'd2; band = 4'd6; pdiv = 8'd100; mdiv = 3'd5; qdiv = 7'd22; end
    endcase
  endtask

  task automatic run_xfer(input int k, input int d, input int st);
    logic [23:0] w;
    logic [2:0]  s0; logic [3:0] b0; logic [7:0] p0; logic [2:0] m0; logic [6:0] q0;
    logic [39:0] cap;
    int ncap;
    int nshift;
    int mism;
    logic prev;
    logic [1:0] el;
    set_fields(k);
    hold = DIV_W'(d);
    settle = SETTLE_W'(st);
    s0 = sel; b0 = band; p0 = pdiv; m0 = mdiv; q0 = qdiv;
    // R2 packing
    w = {s0, b0, 7'(p0 - 8'd3), m0, 7'(q0 - 7'd2)};
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cap = '0; ncap = 0; prev = 1'b1; mism = 0;
    nshift = NSTATES * (d + 1);
    for (int t = 0; t <= nshift + st + 1; t++) begin
      if (t > 0) @(negedge clk);
      if (t < nshift) begin
        el = exp_line(t / (d + 1), w);
        // R4..R8: line state per cycle
        if ({sdat, sclk} !== el) mism++;
        chk({sdat, sclk} === el, "R8 line state", {30'd0, sdat, sclk}, {30'd0, el});
        chk(busy === 1'b1 && done === 1'b0, "R11 busy during shift",
            {30'd0, busy, done}, 32'h2);
      end else if (t <= nshift + st) begin
        chk(sclk === 1'b1 && sdat === 1'b1 && busy === 1'b1 && done === 1'b0,
            "R9 settle", {28'd0, sclk, sdat, busy, done}, 32'he);
      end else begin
        chk(busy === 1'b0 && done === 1'b1 && sclk === 1'b1 && sdat === 1'b1,
            "R9 done pulse", {28'd0, sclk, sdat, busy, done}, 32'hd);
      end
      chk(err === 1'b0, "R10 no error while busy", {31'd0, err}, 32'd0);
      if (sclk === 1'b1 && prev === 1'b0 && ncap < 40) begin
        cap[ncap] = sdat;
        ncap++;
      end
      prev = sclk;
      // R10: request while busy with illegal and changed fields
      if (t == 5) begin
        start = 1'b1; pdiv = 8'd3; qdiv = 7'd99; sel = ~s0;
      end else if (t == 6) begin
        start = 1'b0;
      end
    end
    chk(ncap == 32, "R6 rising edge count", 32'(ncap), 32'd32);
    chk(cap[4:0] == 5'h1f, "R4 preamble bits", {27'd0, cap[4:0]}, 32'h1f);
    chk(cap[6:5] == 2'b00, "R5 start bits", {30'd0, cap[6:5]}, 32'd0);
    chk(cap[30:7] == w, "R2 R6 decoded word", {8'd0, cap[30:7]}, {8'd0, w});
    chk(cap[31] == 1'b1, "R7 stop bit", {31'd0, cap[31]}, 32'd1);
    chk(mism == 0, "R10 stream intact", 32'(mism), 32'd0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic try_bad(input logic [7:0] p, input logic [6:0] q);
    set_fields(2);
    pdiv = p; qdiv = q;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1 && busy === 1'b0, "R3 refusal pulse", {30'd0, err, busy}, 32'h2);
    chk(sclk === 1'b1 && sdat === 1'b1, "R3 lines stay high", {30'd0, sclk, sdat}, 32'h3);
    @(negedge clk);
    chk(err === 1'b0 && busy === 1'b0, "R3 refusal one cycle", {30'd0, err, busy}, 32'd0);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0;
    set_fields(0);
    hold = '0; settle = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(sclk === 1'b1 && sdat === 1'b1 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 reset state", {27'd0, sclk, sdat, busy, done, err}, 32'h18);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sclk === 1'b1 && sdat === 1'b1 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 idle after reset", {27'd0, sclk, sdat, busy, done, err}, 32'h18);

    try_bad(8'd3,   7'd40);
    try_bad(8'd131, 7'd40);
    try_bad(8'd77,  7'd14);
    try_bad(8'd77,  7'd72);

    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 3; d++)
        for (int si = 0; si < 2; si++)
          run_xfer(k, d, si * 3);

    // R3: boundary legal values are accepted right after refusals
    try_bad(8'd255, 7'd0);
    run_xfer(1, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule